// File: doc/BRIEF.md
# Hybrid Two-Structure Translation Lookup

This block finds the entry that maps a virtual address. It searches two stores at once. The first is a set-associative array (default 8 ways of 256 sets) that uses a single page size, taken from a shared page-shift input. The second is a small fully-associative array (default 16 entries), in which each entry holds its own page shift. Every entry covers an even/odd pair of pages. It stores the virtual tag from address bit 13 upward, an address-space identifier, a global flag and an exists flag.

A lookup request with its address is accepted in any cycle. One cycle later a response strobe comes back with a hit flag and a flat entry index. Set-associative entries take indices `way*NSETS + set`. Fully-associative entries come after them. Software refills entries one at a time through a write port addressed by the same flat index. Permission checks and victim selection are left to the surrounding logic.

Top module: `hybrid_tlb_lookup`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) no entry exists, so every lookup misses until an entry is written.
- R2: When req_valid is high at a clock edge, rsp_valid is high in the following cycle together with the result for that request. When req_valid is low, rsp_valid is low in the following cycle. Back-to-back requests give back-to-back responses.
- R3: A write with flat index below NWAYS*NSETS loads way index/NSETS, set index%NSETS of the set-associative array. A write with an index from NWAYS*NSETS up to NWAYS*NSETS+FA_DEPTH-1 loads fully-associative entry index-NWAYS*NSETS. Writes to higher indices change nothing. A hit reports the same flat index.
- R4: The set-associative array is probed only in set va[ps+SET_W : ps+1], where ps = sa_page_shift and SET_W = log2(NSETS).
- R5: An entry's tag matches when va[VA_W-1 : ps+1] equals the stored tag bits [VA_W-14 : ps-12]. The stored tag holds va[VA_W-1:13]. Address bits below ps+1 do not take part, so both halves of the page pair hit the same entry.
- R6: An entry whose exists flag is 0 never hits. Rewriting an entry with the flag cleared removes it.
- R7: An entry hits only if its global flag is 1 or its stored identifier equals cur_asid.
- R8: A fully-associative entry uses its own stored page shift for the R5 compare. sa_page_shift has no effect on it.
- R9: A set-associative hit takes priority over any fully-associative hit. Within the set-associative array the lowest way wins. Within the fully-associative array the lowest entry wins.
- R10: On a miss, rsp_hit is 0 and rsp_index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address to look up |
| cur_asid | input | 10 | Current address-space identifier |
| sa_page_shift | input | 6 | Page shift shared by all set-associative entries (at least 12) |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | IDX_W | Flat index of the entry to write |
| wr_exists | input | 1 | Exists flag to store |
| wr_global | input | 1 | Global flag to store |
| wr_asid | input | 10 | Identifier to store |
| wr_vppn | input | VA_W-13 | Virtual tag, address bits VA_W-1 down to 13 |
| wr_page_shift | input | 6 | Page shift to store (fully-associative entries only) |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | An entry matched |
| rsp_index | output | IDX_W | Flat index of the matching entry, 0 on a miss |

## Verification
The bench targets the cases that are easy to get wrong. One is an address that differs from an entry only below bit ps+1: a design that compares too many bits would miss on the odd half of the pair. Another is a change of the shared page shift. A design that takes the set from fixed address bits, or that applies the shared shift to fully-associative entries, would find entries it should miss and miss entries it should find. Entries that match in both stores and in several ways at once test the priority order. A wrong order shows up as a different flat index. Identifier mismatches with and without the global flag, removals, out-of-range writes and a mid-run reset are checked against a behavioural model on every clock.

// File: rtl/tlbl_pkg.sv
// Package: shared constants and types for the hybrid lookup.
// Assumes: identifiers are 10 bits, page shifts fit in 6 bits,
// stored virtual tags start at address bit 13.
package tlbl_pkg;

    localparam int ASID_W   = 10;
    localparam int PS_W     = 6;
    localparam int VPPN_LSB = 13;

    typedef logic [ASID_W-1:0] asid_t;
    typedef logic [PS_W-1:0]   ps_t;

    // Per-entry match qualifiers.
    typedef struct packed {
        logic  exists;
        logic  global_map;
        asid_t asid;
    } tag_attr_t;

endpackage

// File: rtl/tlbl_tag_cmp.sv
// Module: tlbl_tag_cmp
// Compares one stored entry against the upper address bits of a lookup.
// Bits of the tag that lie below the pair boundary (ps+1) are ignored.
// Assumes: ps is at least VPPN_LSB-1 and below VA_W-1.
module tlbl_tag_cmp
    import tlbl_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic [VA_W-VPPN_LSB-1:0] va_hi,
    input  ps_t                      page_shift,
    input  logic [VA_W-VPPN_LSB-1:0] tag,
    input  tag_attr_t                attr,
    input  asid_t                    cur_asid,
    output logic                     hit
);
    localparam int TAG_W = VA_W - VPPN_LSB;

    logic [TAG_W-1:0] care;
    logic             tag_eq;
    logic             owner_ok;

    // Build the care mask: tag bit i stands for address bit i+VPPN_LSB.
    always_comb begin
        for (int i = 0; i < TAG_W; i++) begin
            care[i] = (i + VPPN_LSB) > int'(page_shift);
        end
    end

    // Decide the hit from the masked compare and the qualifiers.
    always_comb begin
        tag_eq   = ((va_hi ^ tag) & care) == '0;
        owner_ok = attr.global_map || (attr.asid == cur_asid);
        hit      = attr.exists && owner_ok && tag_eq;
    end

endmodule

// File: rtl/tlbl_first_set.sv
// Module: tlbl_first_set
// Finds the lowest set bit of a request vector.
// Assumes: POS_W is wide enough to hold N-1.
module tlbl_first_set #(
    parameter int N     = 8,
    parameter int POS_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [POS_W-1:0] pos
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        pos = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pos = POS_W'(i);
            end
        end
        found = |req;
    end

endmodule

// File: rtl/tlbl_sa_array.sv
// Module: tlbl_sa_array
// Set-associative store. Every way shares one page shift. A lookup reads
// one set from all ways and reports a hit vector by way.
// Assumes: NSETS is a power of two; a write and a lookup in the same cycle
// see the contents from before the write.
module tlbl_sa_array
    import tlbl_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int NWAYS = 8,
    parameter int NSETS = 256,
    localparam int SET_W = $clog2(NSETS),
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int TAG_W = VA_W - VPPN_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [SET_W-1:0] wr_set,
    input  tag_attr_t        wr_attr,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VA_W-1:0]  lk_va,
    input  ps_t              lk_shift,
    input  asid_t            cur_asid,
    output logic [SET_W-1:0] lk_set,
    output logic [NWAYS-1:0] way_hit
);
    // Pick the set bits just above the pair boundary.
    always_comb begin
        for (int b = 0; b < SET_W; b++) begin
            int src;
            src       = int'(lk_shift) + 1 + b;
            lk_set[b] = (src < VA_W) ? lk_va[src] : 1'b0;
        end
    end

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [NSETS-1:0] exists_q;
        logic             glob_q [NSETS];
        asid_t            asid_q [NSETS];
        logic [TAG_W-1:0] tag_q  [NSETS];
        logic             sel;
        tag_attr_t        rd_attr;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        // Exists flags: cleared by reset, set or cleared by writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                exists_q <= '0;
            end else if (sel) begin
                exists_q[wr_set] <= wr_attr.exists;
            end
        end

        // Payload storage: written on refill, no reset needed.
        always_ff @(posedge clk) begin
            if (sel) begin
                glob_q[wr_set] <= wr_attr.global_map;
                asid_q[wr_set] <= wr_attr.asid;
                tag_q[wr_set]  <= wr_tag;
            end
        end

        // Gather the qualifiers of the probed set.
        always_comb begin
            rd_attr.exists     = exists_q[lk_set];
            rd_attr.global_map = glob_q[lk_set];
            rd_attr.asid       = asid_q[lk_set];
        end

        tlbl_tag_cmp #(.VA_W(VA_W)) u_cmp (
            .va_hi      (lk_va[VA_W-1:VPPN_LSB]),
            .page_shift (lk_shift),
            .tag        (tag_q[lk_set]),
            .attr       (rd_attr),
            .cur_asid   (cur_asid),
            .hit        (way_hit[w])
        );
    end

    AST_SA_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (way_hit == '0)); // R1

endmodule

// File: rtl/tlbl_fa_array.sv
// Module: tlbl_fa_array
// Fully-associative store. Every entry keeps its own page shift and is
// compared in parallel with the lookup address.
// Assumes: write offsets at or beyond DEPTH select no entry.
module tlbl_fa_array
    import tlbl_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int DEPTH = 16,
    parameter int OFF_W = 5,
    localparam int TAG_W = VA_W - VPPN_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  tag_attr_t        wr_attr,
    input  logic [TAG_W-1:0] wr_tag,
    input  ps_t              wr_shift,
    input  logic [VA_W-1:0]  lk_va,
    input  asid_t            cur_asid,
    output logic [DEPTH-1:0] ent_hit
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        logic             exists_q;
        logic             glob_q;
        asid_t            asid_q;
        logic [TAG_W-1:0] tag_q;
        ps_t              shift_q;
        logic             sel;
        tag_attr_t        rd_attr;

        assign sel = wr_en && (wr_off == OFF_W'(k));

        // Exists flag: cleared by reset, loaded by writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                exists_q <= 1'b0;
            end else if (sel) begin
                exists_q <= wr_attr.exists;
            end
        end

        // Payload including the private page shift.
        always_ff @(posedge clk) begin
            if (sel) begin
                glob_q  <= wr_attr.global_map;
                asid_q  <= wr_attr.asid;
                tag_q   <= wr_tag;
                shift_q <= wr_shift;
            end
        end

        // Assemble the qualifiers for the comparator.
        always_comb begin
            rd_attr.exists     = exists_q;
            rd_attr.global_map = glob_q;
            rd_attr.asid       = asid_q;
        end

        tlbl_tag_cmp #(.VA_W(VA_W)) u_cmp (
            .va_hi      (lk_va[VA_W-1:VPPN_LSB]),
            .page_shift (shift_q),
            .tag        (tag_q),
            .attr       (rd_attr),
            .cur_asid   (cur_asid),
            .hit        (ent_hit[k])
        );
    end

    AST_FA_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (ent_hit == '0)); // R1

endmodule

// File: rtl/hybrid_tlb_lookup.sv
// Module: hybrid_tlb_lookup
// Top of the hybrid lookup. It decodes the flat write index onto the two
// stores, probes both with the request address, applies the fixed
// priority (set-associative first, lowest way or entry first) and
// registers the result one cycle after the request.
// Assumes: NSETS is a power of two, sa_page_shift and stored shifts lie
// between 12 and VA_W-2.
module hybrid_tlb_lookup
    import tlbl_pkg::*;
#(
    parameter int VA_W     = 48,
    parameter int NWAYS    = 8,
    parameter int NSETS    = 256,
    parameter int FA_DEPTH = 16,
    localparam int TAG_W = VA_W - VPPN_LSB,
    localparam int SET_W = $clog2(NSETS),
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int FA_W  = (FA_DEPTH > 1) ? $clog2(FA_DEPTH) : 1,
    localparam int SA_N  = NWAYS * NSETS,
    localparam int TOTAL = SA_N + FA_DEPTH,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [PS_W-1:0]   sa_page_shift,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_exists,
    input  logic              wr_global,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [TAG_W-1:0]  wr_vppn,
    input  logic [PS_W-1:0]   wr_page_shift,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_index
);
    tag_attr_t           wr_attr;
    logic                sa_wr;
    logic                fa_wr;
    logic [IDX_W-1:0]    fa_off;
    logic [SET_W-1:0]    lk_set;
    logic [NWAYS-1:0]    way_hit;
    logic [FA_DEPTH-1:0] fa_hit;
    logic                sa_found;
    logic                fa_found;
    logic [WAY_W-1:0]    sa_pos;
    logic [FA_W-1:0]     fa_pos;
    logic                nxt_hit;
    logic [IDX_W-1:0]    nxt_index;

    // Split the flat write index between the two stores.
    always_comb begin
        wr_attr.exists     = wr_exists;
        wr_attr.global_map = wr_global;
        wr_attr.asid       = wr_asid;
        sa_wr  = wr_en && (wr_index < IDX_W'(SA_N));
        fa_wr  = wr_en && !(wr_index < IDX_W'(SA_N));
        fa_off = wr_index - IDX_W'(SA_N);
    end

    tlbl_sa_array #(
        .VA_W  (VA_W),
        .NWAYS (NWAYS),
        .NSETS (NSETS)
    ) u_sa (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sa_wr),
        .wr_way   (wr_index[SET_W +: WAY_W]),
        .wr_set   (wr_index[SET_W-1:0]),
        .wr_attr  (wr_attr),
        .wr_tag   (wr_vppn),
        .lk_va    (req_va),
        .lk_shift (sa_page_shift),
        .cur_asid (cur_asid),
        .lk_set   (lk_set),
        .way_hit  (way_hit)
    );

    tlbl_fa_array #(
        .VA_W  (VA_W),
        .DEPTH (FA_DEPTH),
        .OFF_W (IDX_W)
    ) u_fa (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fa_wr),
        .wr_off   (fa_off),
        .wr_attr  (wr_attr),
        .wr_tag   (wr_vppn),
        .wr_shift (wr_page_shift),
        .lk_va    (req_va),
        .cur_asid (cur_asid),
        .ent_hit  (fa_hit)
    );

    tlbl_first_set #(.N(NWAYS), .POS_W(WAY_W)) u_sa_pick (
        .req   (way_hit),
        .found (sa_found),
        .pos   (sa_pos)
    );

    tlbl_first_set #(.N(FA_DEPTH), .POS_W(FA_W)) u_fa_pick (
        .req   (fa_hit),
        .found (fa_found),
        .pos   (fa_pos)
    );

    // Merge the two stores with set-associative priority.
    always_comb begin
        nxt_hit   = sa_found || fa_found;
        nxt_index = '0;
        if (sa_found) begin
            nxt_index = (IDX_W'(sa_pos) << SET_W) | IDX_W'(lk_set);
        end else if (fa_found) begin
            nxt_index = IDX_W'(SA_N) + IDX_W'(fa_pos);
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_index <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit   <= nxt_hit;
                rsp_index <= nxt_index;
            end
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_SA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (|way_hit)) |=> (rsp_hit && (rsp_index < IDX_W'(SA_N)))); // R9
    AST_FA_AFTER_SA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(|way_hit) && (|fa_hit)) |=> (rsp_hit && !(rsp_index < IDX_W'(SA_N)))); // R9
    AST_MISS_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(|way_hit) && !(|fa_hit)) |=> (!rsp_hit && (rsp_index == '0))); // R10

endmodule

// File: tb/hybrid_tlb_lookup_tb_top.sv
// Bench: behavioural model of the lookup, compared on every clock, plus
// directed lookups with hand-derived expected results.
module hybrid_tlb_lookup_tb_top;
    localparam int VA_W  = 48;
    localparam int NW    = 4;
    localparam int NS    = 16;
    localparam int NF    = 8;
    localparam int SA_N  = NW * NS;
    localparam int TOTAL = SA_N + NF;
    localparam int IDX_W = $clog2(TOTAL);
    localparam int TAG_W = VA_W - 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_va = '0;
    logic [9:0]        cur_asid = '0;
    logic [5:0]        sa_page_shift = 6'd14;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_index = '0;
    logic              wr_exists = 1'b0;
    logic              wr_global = 1'b0;
    logic [9:0]        wr_asid = '0;
    logic [TAG_W-1:0]  wr_vppn = '0;
    logic [5:0]        wr_page_shift = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [IDX_W-1:0]  rsp_index;

    hybrid_tlb_lookup #(
        .VA_W(VA_W), .NWAYS(NW), .NSETS(NS), .FA_DEPTH(NF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .cur_asid(cur_asid), .sa_page_shift(sa_page_shift), .wr_en(wr_en),
        .wr_index(wr_index), .wr_exists(wr_exists), .wr_global(wr_global),
        .wr_asid(wr_asid), .wr_vppn(wr_vppn), .wr_page_shift(wr_page_shift),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_tag = "R1 reset";

    // Model state
    bit              m_e [TOTAL];
    bit              m_g [TOTAL];
    int              m_asid [TOTAL];
    longint unsigned m_vppn [TOTAL];
    int              m_ps [TOTAL];
    bit              exp_valid = 0;
    bit              exp_hit = 0;
    int              exp_idx = 0;

    function automatic bit ent_match(int i, longint unsigned va, int ps);
        longint unsigned vpn = va >> (ps + 1);
        longint unsigned tg  = m_vppn[i] >> (ps + 1 - 13);
        return m_e[i] && (m_g[i] || m_asid[i] == int'(cur_asid)) && (vpn == tg);
    endfunction

    task automatic model_lookup(input longint unsigned va, output bit h, output int idx);
        int sps = int'(sa_page_shift);
        int set = int'((va >> (sps + 1)) % NS);
        h = 0; idx = 0;
        for (int w = 0; w < NW; w++) begin
            if (!h && ent_match(w * NS + set, va, sps)) begin h = 1; idx = w * NS + set; end
        end
        for (int k = SA_N; k < TOTAL; k++) begin
            if (!h && ent_match(k, va, m_ps[k])) begin h = 1; idx = k; end
        end
    endtask

    // Model update at each rising edge: lookup sees old contents, then write.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (m_e[i]) m_e[i] = 0;
            exp_valid = 0;
        end else begin
            exp_valid = req_valid;
            if (req_valid) model_lookup(longint'(req_va), exp_hit, exp_idx);
            if (wr_en && int'(wr_index) < TOTAL) begin
                m_e[wr_index]    = wr_exists;
                m_g[wr_index]    = wr_global;
                m_asid[wr_index] = int'(wr_asid);
                m_vppn[wr_index] = longint'(wr_vppn);
                m_ps[wr_index]   = int'(wr_page_shift);
            end
        end
        armed = 1;
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (rsp_valid !== exp_valid ||
                (exp_valid && (rsp_hit !== exp_hit || int'(rsp_index) != exp_idx))) begin
                errors++;
                $display("FAIL %s: got v=%0d h=%0d idx=%0d expected v=%0d h=%0d idx=%0d",
                         cur_tag, rsp_valid, rsp_hit, rsp_index, exp_valid, exp_hit, exp_idx);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got cycles=%0d expected at most 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_write(input int idx, input longint unsigned va, input bit e,
                            input bit g, input int asid, input int ps);
        @(negedge clk);
        wr_en = 1; wr_index = IDX_W'(idx); wr_exists = e; wr_global = g;
        wr_asid = 10'(asid); wr_vppn = TAG_W'(va >> 13); wr_page_shift = 6'(ps);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_lookup(input longint unsigned va, input bit eh, input int ei, input string tag);
        cur_tag = tag;
        @(negedge clk);
        req_valid = 1; req_va = VA_W'(va);
        @(negedge clk);
        req_valid = 0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || int'(rsp_index) != (eh ? ei : 0)) begin
            errors++;
            $display("FAIL %s: got v=%0d h=%0d idx=%0d expected v=1 h=%0d idx=%0d",
                     tag, rsp_valid, rsp_hit, rsp_index, eh, eh ? ei : 0);
        end
    endtask

    longint unsigned a_va, b_va, c_va;
    longint unsigned pool [6];

    initial begin
        a_va = (64'h1234 << 19) | (64'd5 << 15);
        c_va = (64'h00F0 << 24) | (64'd9 << 17);
        b_va = 64'h00AB_0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 / R10: empty after reset
        cur_asid = 10'd3;
        do_lookup(64'd0, 0, 0, "R1 lookup after reset misses");
        do_lookup(a_va, 0, 0, "R10 miss returns index zero");

        // R3 / R4 / R5: set-associative entry way 2 set 5 -> flat 37
        do_write(2 * NS + 5, a_va, 1, 0, 3, 0);
        do_lookup(a_va, 1, 37, "R3 flat index of way 2 set 5");
        do_lookup(a_va | 64'h4000 | 64'h3FFF, 1, 37, "R5 odd half and offset ignored");
        do_lookup(a_va ^ (64'd1 << 30), 0, 0, "R5 upper tag bit differs");

        // R7: identifier and global flag
        cur_asid = 10'd4;
        do_lookup(a_va, 0, 0, "R7 identifier mismatch misses");
        do_write(37, a_va, 1, 1, 3, 0);
        do_lookup(a_va, 1, 37, "R7 global flag overrides identifier");

        // R6: removal
        do_write(37, a_va, 0, 1, 3, 0);
        do_lookup(a_va, 0, 0, "R6 cleared exists flag misses");

        // R4: shared shift 16, set from va[20:17] = 9 -> way 1 -> flat 25
        sa_page_shift = 6'd16;
        do_write(NS + 9, c_va, 1, 1, 0, 0);
        do_lookup(c_va | (64'd1 << 16), 1, 25, "R4 set taken above shift 16");
        sa_page_shift = 6'd14;
        do_lookup(c_va, 0, 0, "R4 other shift probes another set");

        // R8: associative entry with its own shift 21 -> flat 67
        do_write(SA_N + 3, b_va, 1, 1, 0, 21);
        do_lookup(b_va | (64'd1 << 21) | 64'h1FFFF, 1, 67, "R8 own shift 21 at shared 14");
        sa_page_shift = 6'd16;
        do_lookup(b_va | (64'd1 << 21), 1, 67, "R8 shared shift has no effect");
        do_lookup(b_va | (64'd1 << 22), 0, 0, "R8 bit above own boundary differs");

        // R9: priorities
        do_write(SA_N + 1, b_va, 1, 1, 0, 21);
        do_lookup(b_va, 1, 65, "R9 lowest associative entry wins");
        sa_page_shift = 6'd14;
        do_write(3 * NS + 0, b_va, 1, 1, 0, 0);
        do_lookup(b_va, 1, 48, "R9 set-associative beats associative");
        do_write(1 * NS + 0, b_va, 1, 1, 0, 0);
        do_lookup(b_va, 1, 16, "R9 lowest way wins");

        // R3: write beyond the last entry changes nothing
        do_write(TOTAL, a_va, 1, 1, 0, 21);
        do_lookup(a_va, 0, 0, "R3 out-of-range write ignored");

        // R2: back-to-back requests and idle gap, model-checked every clock
        cur_tag = "R2 back-to-back";
        @(negedge clk);
        req_valid = 1; req_va = VA_W'(b_va);
        @(negedge clk);
        req_va = VA_W'(c_va);
        @(negedge clk);
        req_va = VA_W'(a_va);
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);

        // Random mix against the model (R3..R9)
        cur_tag = "R9 random mix";
        for (int k = 0; k < 6; k++) pool[k] = (longint'(k + 1) * 64'h0003_5791_0000) & 64'hFFFF_FFFF_FFFF;
        for (int it = 0; it < 600; it++) begin
            int p = int'($urandom % 6);
            @(negedge clk);
            if ($urandom % 8 == 0) sa_page_shift = 6'(($urandom % 2) ? 14 : (($urandom % 2) ? 13 : 16));
            cur_asid  = 10'(1 + $urandom % 2);
            req_valid = ($urandom % 2) == 1;
            req_va    = VA_W'(pool[p] ^ longint'($urandom % 32'h1_0000));
            wr_en     = ($urandom % 3) == 0;
            wr_exists = ($urandom % 6) != 0;
            wr_global = ($urandom % 4) == 0;
            wr_asid   = 10'(1 + $urandom % 2);
            wr_vppn   = TAG_W'(pool[$urandom % 6] >> 13);
            wr_page_shift = 6'(13 + $urandom % 10);
            if ($urandom % 2) begin
                int sps = int'(sa_page_shift);
                int set = int'((longint'(wr_vppn) << 13 >> (sps + 1)) % NS);
                wr_index = IDX_W'(int'($urandom % NW) * NS + set);
            end else begin
                wr_index = IDX_W'(SA_N + int'($urandom % (NF + 1)));
            end
        end
        @(negedge clk);
        req_valid = 0; wr_en = 0;

        // R1: mid-run reset empties both stores
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        cur_asid = 10'd0;
        do_lookup(b_va, 0, 0, "R1 second reset clears entries");
        do_lookup(pool[0], 0, 0, "R1 second reset clears pool entry");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule